// File: doc/BRIEF.md
# Instruction Cache Way

This unit is one way of an instruction cache. It keeps, for every set, a tag entry (stored tag plus a valid flag) and a block of instruction words. The incoming word address is split into an offset, an index and a tag. On every cycle the way reads the entry and the block at the index, reports a hit when the entry is valid and its tag matches, and presents the instruction word chosen by the offset.

A cache controller outside this unit drives refills and invalidation through the same address. A refill writes the block one instruction word per cycle and then writes the tag, which marks the entry valid. An invalidate clears the valid flag of the addressed set and leaves the block data untouched. All internal stores are single-port register arrays with write-first behaviour, so a write is visible on the outputs in the cycle it is issued. The block data may be spread over several narrower banks, each holding a fixed number of instruction words.

Top module: `icache_way`

## Requirements
- R1: After reset every set is invalid, so `hit_o` is 0 for every address until a tag write occurs.
- R2: The word address is split with the offset in the lowest log2(BLOCK_INSTR) bits, the index in the next log2(NUM_SETS) bits and the tag in the top TAG_W bits.
- R3: `hit_o` is 1 only when the indexed entry is valid and its stored tag equals the tag field of `addr_i`; a differing tag (including a difference only in the top tag bit) gives 0.
- R4: A tag write stores the address tag with the valid flag set at the indexed set, and `hit_o` reflects it in the same cycle.
- R5: A fill write stores `fill_data_i` into the word selected by index and offset, shows it on `instr_o` in the same cycle, and leaves the other words of the block unchanged.
- R6: An invalidate clears the valid flag of the indexed set only (`hit_o` is 0 in that cycle), keeps the block data, and leaves other sets' entries valid.
- R7: When invalidate and tag write are issued in the same cycle, invalidate wins and the set is left invalid.
- R8: `instr_o` returns the stored word at the addressed index and offset whether or not the lookup hits, and with no write and an unchanged address both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all valid flags |
| addr_i | input | TAG_W+log2(NUM_SETS)+log2(BLOCK_INSTR) | Word address used for lookup and all writes |
| fill_we_i | input | 1 | Write `fill_data_i` into the addressed block word |
| fill_data_i | input | INSTR_W | Refill instruction word |
| tag_we_i | input | 1 | Store the address tag and set the valid flag |
| inv_we_i | input | 1 | Clear the valid flag of the addressed set |
| hit_o | output | 1 | Lookup hit |
| instr_o | output | INSTR_W | Instruction word at the addressed index and offset |

## Verification
The bench fills a block word by word and checks that each word appears on the output in the write cycle, which a design with a read-before-write store would miss by one cycle. It compares tags that differ only in the top bit and reads neighbouring sets, catching a truncated comparator or a wrong index slice. It invalidates a set and then re-tags it without refilling, so a design that cleared the data or hit another set shows stale or wrong words. It issues invalidate and tag write together, where a design with the wrong priority would report a hit.

// File: rtl/icw_pkg.sv
package icw_pkg;

   // True when v is a nonzero power of two.
   function automatic bit icw_is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/icw_sp_ram.sv
// Single-port register array with per-lane write enables and write-first read.
module icw_sp_ram #(
   parameter int unsigned LANE_W  = 32,
   parameter int unsigned LANES   = 1,
   parameter int unsigned DEPTH   = 8,
   parameter bit          HAS_RST = 1'b0
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [$clog2(DEPTH)-1:0]  addr_i,
   input  logic [LANES-1:0]          we_i,
   input  logic [LANES*LANE_W-1:0]   wdata_i,
   output logic [LANES*LANE_W-1:0]   rdata_o
);
   localparam int unsigned WORD_W = LANES * LANE_W;

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [WORD_W-1:0] stored;

   initial begin
      assert (icw_pkg::icw_is_pow2(DEPTH) && DEPTH >= 2)
         else $error("icw_sp_ram: DEPTH must be a power of two, at least 2");
   end

   if (HAS_RST) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int e = 0; e < int'(DEPTH); e++) mem_q[e] <= '0;
         end else begin
            for (int l = 0; l < int'(LANES); l++)
               if (we_i[l]) mem_q[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk_i) begin
         for (int l = 0; l < int'(LANES); l++)
            if (we_i[l]) mem_q[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
   end

   assign stored = mem_q[addr_i];

   for (genvar l = 0; l < LANES; l++) begin : g_bypass
      assign rdata_o[l*LANE_W +: LANE_W] =
         we_i[l] ? wdata_i[l*LANE_W +: LANE_W] : stored[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/icw_tag_match.sv
// Compares a stored tag entry with the incoming tag field.
module icw_tag_match #(
   parameter int unsigned TAG_W = 8
) (
   input  logic             entry_valid_i,
   input  logic [TAG_W-1:0] entry_tag_i,
   input  logic [TAG_W-1:0] probe_tag_i,
   output logic             match_o
);
   assign match_o = entry_valid_i && (entry_tag_i == probe_tag_i);
endmodule

// File: rtl/icache_way.sv
module icache_way #(
   parameter int unsigned INSTR_W     = 32,
   parameter int unsigned BLOCK_INSTR = 4,
   parameter int unsigned NUM_SETS    = 8,
   parameter int unsigned TAG_W       = 6,
   parameter int unsigned BANK_INSTR  = 2,
   localparam int unsigned OFF_W      = $clog2(BLOCK_INSTR),
   localparam int unsigned IDX_W      = $clog2(NUM_SETS),
   localparam int unsigned ADDR_W     = TAG_W + IDX_W + OFF_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               fill_we_i,
   input  logic [INSTR_W-1:0] fill_data_i,
   input  logic               tag_we_i,
   input  logic               inv_we_i,
   output logic               hit_o,
   output logic [INSTR_W-1:0] instr_o
);
   localparam int unsigned NUM_BANKS = BLOCK_INSTR / BANK_INSTR;
   localparam int unsigned ENTRY_W   = TAG_W + 1;

   initial begin
      assert (icw_pkg::icw_is_pow2(BLOCK_INSTR) && BLOCK_INSTR >= 2)
         else $error("icache_way: BLOCK_INSTR must be a power of two, at least 2");
      assert (icw_pkg::icw_is_pow2(NUM_SETS) && NUM_SETS >= 2)
         else $error("icache_way: NUM_SETS must be a power of two, at least 2");
      assert (icw_pkg::icw_is_pow2(BANK_INSTR) && BANK_INSTR <= BLOCK_INSTR)
         else $error("icache_way: BANK_INSTR must be a power of two not above BLOCK_INSTR");
      assert (TAG_W >= 1 && INSTR_W >= 1)
         else $error("icache_way: TAG_W and INSTR_W must be positive");
   end

   // Address fields (R2).
   logic [OFF_W-1:0] off;
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   assign off = addr_i[OFF_W-1:0];
   assign idx = addr_i[OFF_W +: IDX_W];
   assign tag = addr_i[ADDR_W-1 -: TAG_W];

   // Tag store: {tag, valid}; invalidate overrides a tag write (R7).
   logic               tag_store_we;
   logic [ENTRY_W-1:0] tag_wdata;
   logic [ENTRY_W-1:0] entry_rd;
   assign tag_store_we = tag_we_i | inv_we_i;
   assign tag_wdata    = {tag, ~inv_we_i};

   icw_sp_ram #(
      .LANE_W (ENTRY_W),
      .LANES  (1),
      .DEPTH  (NUM_SETS),
      .HAS_RST(1'b1)
   ) tag_ram_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (idx),
      .we_i   (tag_store_we),
      .wdata_i(tag_wdata),
      .rdata_o(entry_rd)
   );

   icw_tag_match #(.TAG_W(TAG_W)) match_i (
      .entry_valid_i(entry_rd[0]),
      .entry_tag_i  (entry_rd[ENTRY_W-1:1]),
      .probe_tag_i  (tag),
      .match_o      (hit_o)
   );

   // Block data spread over NUM_BANKS banks of BANK_INSTR words each.
   logic [BLOCK_INSTR-1:0] word_we;
   logic [INSTR_W-1:0]     block_words [BLOCK_INSTR];

   always_comb begin
      word_we = '0;
      word_we[off] = fill_we_i;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_INSTR*INSTR_W-1:0] bank_rd;

      icw_sp_ram #(
         .LANE_W (INSTR_W),
         .LANES  (BANK_INSTR),
         .DEPTH  (NUM_SETS),
         .HAS_RST(1'b0)
      ) data_ram_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .addr_i (idx),
         .we_i   (word_we[b*BANK_INSTR +: BANK_INSTR]),
         .wdata_i({BANK_INSTR{fill_data_i}}),
         .rdata_o(bank_rd)
      );

      for (genvar l = 0; l < BANK_INSTR; l++) begin : g_lane
         assign block_words[b*BANK_INSTR + l] = bank_rd[l*INSTR_W +: INSTR_W];
      end
   end

   assign instr_o = block_words[off];

   // Checks ------------------------------------------------------------
   logic armed_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= 1'b1;
   end

   // R4: a tag write without invalidate hits in the same cycle.
   a_r4_tag_write_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tag_we_i && !inv_we_i) |-> hit_o);

   // R6 / R7: any invalidate forces a miss in its cycle.
   a_r7_inv_forces_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inv_we_i |-> !hit_o);

   // R5: fill data is visible on the output in the write cycle.
   a_r5_fill_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_we_i |-> (instr_o == fill_data_i));

   // R8: no write and an unchanged address keep both outputs steady.
   a_r8_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
      (!fill_we_i && !tag_we_i && !inv_we_i && $stable(addr_i))
         |-> ($stable(hit_o) && $stable(instr_o)));

   // R1: directly after reset no entry can hit without a tag write.
   a_r1_reset_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_q && !tag_we_i) |-> !hit_o);

endmodule

// File: tb/icache_way_tb_top.sv
module icache_way_tb_top;
   localparam int unsigned INSTR_W = 32;
   localparam int unsigned TAG_W   = 6;
   localparam int unsigned ADDR_W  = TAG_W + 3 + 2;
   localparam int unsigned NVEC    = 25;

   typedef struct packed {
      logic        inv;
      logic        tagw;
      logic        fill;
      logic [5:0]  tag;
      logic [2:0]  idx;
      logic [1:0]  off;
      logic [31:0] data;
      logic        exp_hit;
      logic        chk_instr;
      logic [31:0] exp_instr;
      logic [3:0]  req;
   } vec_t;

   function automatic vec_t mkv(logic inv, logic tagw, logic fill, logic [5:0] t,
                                logic [2:0] i, logic [1:0] o, logic [31:0] d,
                                logic eh, logic ci, logic [31:0] ei, logic [3:0] r);
      vec_t v;
      v = '{inv, tagw, fill, t, i, o, d, eh, ci, ei, r};
      return v;
   endfunction

   localparam logic [31:0] A0 = 32'hA000_0000, A1 = 32'hA111_1111,
                           A2 = 32'hA222_2222, A3 = 32'hA333_3333,
                           B1 = 32'hB111_0001, C1 = 32'hC111_0001,
                           D3 = 32'hD333_0003;

   // Fields: inv tagw fill tag idx off data exp_hit chk_instr exp_instr req
   localparam vec_t VEC [NVEC] = '{
      mkv(0,0,0, 6'd5, 3'd2,2'd0, 32'd0, 0,0, 32'd0, 4'd1),  // R1 empty
      mkv(0,0,1, 6'd5, 3'd2,2'd0, A0,    0,1, A0,    4'd5),  // R5 same-cycle fill
      mkv(0,0,1, 6'd5, 3'd2,2'd1, A1,    0,1, A1,    4'd5),
      mkv(0,0,1, 6'd5, 3'd2,2'd2, A2,    0,1, A2,    4'd5),
      mkv(0,0,1, 6'd5, 3'd2,2'd3, A3,    0,1, A3,    4'd5),
      mkv(0,1,0, 6'd5, 3'd2,2'd0, 32'd0, 1,1, A0,    4'd4),  // R4 tag write
      mkv(0,0,0, 6'd5, 3'd2,2'd1, 32'd0, 1,1, A1,    4'd3),  // R3 hit
      mkv(0,0,0, 6'd5, 3'd2,2'd3, 32'd0, 1,1, A3,    4'd2),  // R2 offset field
      mkv(0,0,0, 6'd6, 3'd2,2'd2, 32'd0, 0,1, A2,    4'd8),  // R8 miss still reads
      mkv(0,0,0, 6'd5, 3'd3,2'd0, 32'd0, 0,0, 32'd0, 4'd2),  // R2 index field
      mkv(0,0,1, 6'd9, 3'd3,2'd1, B1,    0,1, B1,    4'd5),
      mkv(0,1,0, 6'd9, 3'd3,2'd1, 32'd0, 1,1, B1,    4'd4),
      mkv(0,0,0, 6'd5, 3'd2,2'd2, 32'd0, 1,1, A2,    4'd3),
      mkv(1,0,0, 6'd5, 3'd2,2'd0, 32'd0, 0,0, 32'd0, 4'd6),  // R6 invalidate
      mkv(0,0,0, 6'd5, 3'd2,2'd2, 32'd0, 0,1, A2,    4'd6),  // R6 data kept
      mkv(0,0,0, 6'd9, 3'd3,2'd1, 32'd0, 1,1, B1,    4'd6),  // R6 other set
      mkv(1,1,0, 6'd5, 3'd2,2'd0, 32'd0, 0,0, 32'd0, 4'd7),  // R7 inv wins
      mkv(0,0,0, 6'd5, 3'd2,2'd0, 32'd0, 0,1, A0,    4'd7),
      mkv(0,1,0, 6'd5, 3'd2,2'd0, 32'd0, 1,1, A0,    4'd6),
      mkv(0,0,1, 6'd5, 3'd2,2'd1, C1,    1,1, C1,    4'd5),
      mkv(0,0,0, 6'd5, 3'd2,2'd0, 32'd0, 1,1, A0,    4'd5),  // R5 neighbour kept
      mkv(0,0,0, 6'd5, 3'd2,2'd1, 32'd0, 1,1, C1,    4'd5),
      mkv(0,0,1, 6'd63,3'd7,2'd3, D3,    0,1, D3,    4'd5),
      mkv(0,1,0, 6'd63,3'd7,2'd3, 32'd0, 1,1, D3,    4'd3),
      mkv(0,0,0, 6'd31,3'd7,2'd3, 32'd0, 0,1, D3,    4'd3)   // R3 top tag bit
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [ADDR_W-1:0]  addr = '0;
   logic               fill_we = 1'b0;
   logic [INSTR_W-1:0] fill_data = '0;
   logic               tag_we = 1'b0;
   logic               inv_we = 1'b0;
   logic               hit;
   logic [INSTR_W-1:0] instr;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;

   always #5 clk = ~clk;

   icache_way #(
      .INSTR_W(INSTR_W), .BLOCK_INSTR(4), .NUM_SETS(8), .TAG_W(TAG_W), .BANK_INSTR(2)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .fill_we_i(fill_we),
      .fill_data_i(fill_data), .tag_we_i(tag_we), .inv_we_i(inv_we),
      .hit_o(hit), .instr_o(instr)
   );

   task automatic check_hit(logic exp, int unsigned req, int unsigned step);
      n_tests++;
      if (hit !== exp) begin
         n_fail++;
         $display("FAIL R%0d step %0d hit actual=%0b expected=%0b", req, step, hit, exp);
      end
   endtask

   task automatic check_instr(logic [31:0] exp, int unsigned req, int unsigned step);
      n_tests++;
      if (instr !== exp) begin
         n_fail++;
         $display("FAIL R%0d step %0d instr actual=%h expected=%h", req, step, instr, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, several sets.
      for (int s = 0; s < 8; s++) begin
         @(negedge clk);
         addr = {6'd5, 3'(s), 2'd0};
         #2 check_hit(1'b0, 1, 100 + s);
      end

      for (int k = 0; k < int'(NVEC); k++) begin
         @(negedge clk);
         addr      = {VEC[k].tag, VEC[k].idx, VEC[k].off};
         inv_we    = VEC[k].inv;
         tag_we    = VEC[k].tagw;
         fill_we   = VEC[k].fill;
         fill_data = VEC[k].data;
         #2;
         check_hit(VEC[k].exp_hit, VEC[k].req, k);
         if (VEC[k].chk_instr) check_instr(VEC[k].exp_instr, VEC[k].req, k);
      end

      @(negedge clk);
      inv_we = 1'b0; tag_we = 1'b0; fill_we = 1'b0;

      // R8: idle cycles with a steady address keep the outputs.
      addr = {6'd9, 3'd3, 2'd1};
      repeat (3) @(negedge clk);
      #2;
      check_hit(1'b1, 8, 200);
      check_instr(B1, 8, 201);

      // R1: a second reset drops every valid entry.
      @(negedge clk);
      rst_n = 1'b0;
      #2 check_hit(1'b0, 1, 202);
      @(negedge clk);
      rst_n = 1'b1;
      addr = {6'd63, 3'd7, 2'd3};
      #2 check_hit(1'b0, 1, 203);
      @(negedge clk);
      addr = {6'd5, 3'd2, 2'd2};
      #2 check_hit(1'b0, 1, 204);

      @(negedge clk);
      finish_run();
   end
endmodule